// File: doc/BRIEF.md
# Block-Addressed Sector Reader with DMA Completion Interrupt

This block is the front end of a disk controller. A host programs it through a small register port. It writes a logical block number and a destination memory address, then writes a command word that starts a read. The engine turns the block number into a physical position: a surface, a track and a sector. It uses a fixed geometry in which the last few tracks of every surface are held back as spares. It then pulls the addressed sector out of a sector-storage model and pushes it into main memory as a bus master. It moves one word per accepted beat and raises a level interrupt when the sector has landed.

The geometry uses these names: sectors per track S, surfaces F, tracks per surface T, and spare tracks P. The usable block count is S*F*(T-P). A block number at or beyond that count ends the command with an error and the interrupt, and no memory traffic takes place. The job parameters are captured when the command starts. The host may therefore rewrite the block number or the address registers while a transfer runs. A second start command during a job is dropped and recorded as an overrun.

Top module: `blkdma_top`

## Requirements
- R1: After reset, memValid and irq are low and the status register (offset 3) reads 0.
- R2: Register offsets are 1 = logical block number and 2 = destination address. Both read back the last value written. Offset 3 reads status: bit0 busy, bit1 done (mirrors irq), bit2 range error, bit3 overrun, all other bits 0.
- R3: Writing offset 0 with bit0 = 1 while idle starts a read. The physical position is sector = LBA mod S, surface = (LBA div S) mod F, track = (LBA div S) div F, with defaults S=8, F=2, T=16, P=2. Beat i carries data {surface[7:0], track[7:0], sector[7:0], i[7:0]}, with the surface in the most significant byte.
- R4: A block number of S*F*(T-P) or more (224 by default) sets the error bit and irq and produces no beats. Block 223 transfers normally.
- R5: A read produces exactly 32 beats of 32 bits. The first address is the destination address, and each accepted beat adds 4 to it.
- R6: While memValid is high and memReady is low, memValid, memAddr and memData hold their values.
- R7: irq rises in the cycle after the last accepted beat, or after a range error. It stays high until offset 3 is written with bit1 = 1. Writing 1 to status bit2 clears the error bit and writing 1 to bit3 clears the overrun bit.
- R8: A start command written while busy is ignored and sets the overrun bit. The running transfer still completes with its original block number and address, even if offsets 1 and 2 are rewritten during it.
- R9: A write to offset 0 with bit0 = 0 starts nothing.
- R10: Status bit0 reads 1 from the cycle after a start command until the job ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on regAddr) |
| memValid | output | 1 | Memory write beat valid |
| memReady | input | 1 | Memory accepts the beat |
| memAddr | output | 32 | Memory byte address of the beat |
| memData | output | 32 | Memory write data of the beat |
| irq | output | 1 | Completion interrupt, level |

## Verification
Each beat's data word carries the latched surface, track and sector fields. A wrong division, modulo or latch therefore shows in the first beat of the transfer, and a wrong beat counter shows in the low byte of the first wrong beat. A wrong transfer length or address step shows as a beat count other than 32, or as an address mismatch, at most one beat after the step goes wrong. A bad flag update shows at the status register on the next read, and a wrong range limit shows as beats appearing for block 224 or missing for block 223.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;
  typedef struct packed {
    logic loadJob;
    logic beatAdv;
  } ctlStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_XLAT, ST_XFER} ctlState_t;

  localparam logic [1:0] REG_CMD  = 2'd0;
  localparam logic [1:0] REG_LBA  = 2'd1;
  localparam logic [1:0] REG_DST  = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;
endpackage

// File: rtl/blkdma_ctrl.sv
module blkdma_ctrl
  import blkdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       statWr,
  input  logic [2:0] statClr,
  input  logic       rangeBad,
  input  logic       lastBeat,
  input  logic       memReady,
  output ctlStrobe_t strobe,
  output logic       memValid,
  output logic       busy,
  output logic       irqFlag,
  output logic       errFlag,
  output logic       ovrFlag
);
  ctlState_t state;
  logic setDone, setErr;

  assign busy     = (state != ST_IDLE);
  assign memValid = (state == ST_XFER);
  assign setErr   = (state == ST_XLAT) && rangeBad;
  assign setDone  = setErr || ((state == ST_XFER) && memReady && lastBeat);

  always_comb begin
    strobe = '0;
    strobe.loadJob = (state == ST_XLAT) && !rangeBad;
    strobe.beatAdv = (state == ST_XFER) && memReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      irqFlag <= 1'b0;
      errFlag <= 1'b0;
      ovrFlag <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cmdStart) state <= ST_XLAT;
        ST_XLAT: state <= rangeBad ? ST_IDLE : ST_XFER;
        ST_XFER: if (memReady && lastBeat) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase

      if (setDone)                     irqFlag <= 1'b1;
      else if (statWr && statClr[0])   irqFlag <= 1'b0;

      if (setErr)                      errFlag <= 1'b1;
      else if (statWr && statClr[1])   errFlag <= 1'b0;

      if (cmdStart && busy)            ovrFlag <= 1'b1;
      else if (statWr && statClr[2])   ovrFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/blkdma_dp.sv
module blkdma_dp
  import blkdma_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int BEATS        = 32,
  parameter int SECT_PER_TRK = 8,
  parameter int SURFACES     = 2,
  parameter int TRACKS       = 16,
  parameter int SPARE_TRACKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [3:0]        statusIn,
  input  ctlStrobe_t        strobe,
  output logic              rangeBad,
  output logic              lastBeat,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);
  localparam int FIELD_W = DATA_W / 4;
  localparam int IDX_W   = $clog2(BEATS);
  localparam int STEP    = DATA_W / 8;
  localparam int USABLE  = SECT_PER_TRK * SURFACES * (TRACKS - SPARE_TRACKS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

  logic [DATA_W-1:0]  lbaReg;
  logic [ADDR_W-1:0]  dstReg;
  logic [DATA_W-1:0]  secW, quoW, surfW, trkW, idxW;
  logic [FIELD_W-1:0] secQ, surfQ, trkQ;
  logic [IDX_W-1:0]   idxQ;
  logic [ADDR_W-1:0]  addrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lbaReg <= '0;
      dstReg <= '0;
    end else if (regWe) begin
      if (regAddr == REG_LBA) lbaReg <= regWdata;
      if (regAddr == REG_DST) dstReg <= ADDR_W'(regWdata);
    end
  end

  // geometry translation from the programmed block number
  always_comb begin
    secW  = lbaReg % DATA_W'(SECT_PER_TRK);
    quoW  = lbaReg / DATA_W'(SECT_PER_TRK);
    surfW = quoW % DATA_W'(SURFACES);
    trkW  = quoW / DATA_W'(SURFACES);
  end
  assign rangeBad = (lbaReg >= DATA_W'(USABLE));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ  <= '0;
      surfQ <= '0;
      trkQ  <= '0;
      idxQ  <= '0;
      addrQ <= '0;
    end else if (strobe.loadJob) begin
      secQ  <= secW[FIELD_W-1:0];
      surfQ <= surfW[FIELD_W-1:0];
      trkQ  <= trkW[FIELD_W-1:0];
      idxQ  <= '0;
      addrQ <= dstReg;
    end else if (strobe.beatAdv) begin
      idxQ  <= idxQ + 1'b1;
      addrQ <= addrQ + ADDR_W'(STEP);
    end
  end

  assign lastBeat = (idxQ == LAST_IDX);
  assign idxW     = DATA_W'(idxQ);
  assign memAddr  = addrQ;
  // sector storage model: word content derived from its physical position
  assign memData  = {surfQ, trkQ, secQ, idxW[FIELD_W-1:0]};

  always_comb begin
    case (regAddr)
      REG_LBA:  regRdata = lbaReg;
      REG_DST:  regRdata = DATA_W'(dstReg);
      REG_STAT: regRdata = DATA_W'(statusIn);
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/blkdma_top.sv
module blkdma_top
  import blkdma_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int SECTOR_BYTES = 128,
  parameter int SECT_PER_TRK = 8,
  parameter int SURFACES     = 2,
  parameter int TRACKS       = 16,
  parameter int SPARE_TRACKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              memValid,
  input  logic              memReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              irq
);
  localparam int BEATS = SECTOR_BYTES / (DATA_W / 8);

  ctlStrobe_t strobe;
  logic cmdStart, statWr, rangeBad, lastBeat;
  logic busy, irqFlag, errFlag, ovrFlag;

  assign cmdStart = regWe && (regAddr == REG_CMD) && regWdata[0];
  assign statWr   = regWe && (regAddr == REG_STAT);
  assign irq      = irqFlag;

  blkdma_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .statWr(statWr),
    .statClr(regWdata[3:1]), .rangeBad(rangeBad), .lastBeat(lastBeat),
    .memReady(memReady), .strobe(strobe), .memValid(memValid), .busy(busy),
    .irqFlag(irqFlag), .errFlag(errFlag), .ovrFlag(ovrFlag)
  );

  blkdma_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS),
    .SECT_PER_TRK(SECT_PER_TRK), .SURFACES(SURFACES),
    .TRACKS(TRACKS), .SPARE_TRACKS(SPARE_TRACKS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .statusIn({ovrFlag, errFlag, irqFlag, busy}), .strobe(strobe),
    .rangeBad(rangeBad), .lastBeat(lastBeat),
    .memAddr(memAddr), .memData(memData)
  );
endmodule

// File: rtl/blkdma_chk.sv
module blkdma_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [1:0]        regAddr,
  input logic              wBit0,
  input logic              wBit1,
  input logic              memValid,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memData,
  input logic              irq,
  input logic              busy,
  input logic              errFlag,
  input logic              ovrFlag
);
  localparam int STEP = DATA_W / 8;

  // R6
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memData));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memReady |=> !memValid || (memAddr == $past(memAddr) + ADDR_W'(STEP)));

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(memValid && memReady) || errFlag);

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq && !(regWe && regAddr == 2'd3 && wBit1) |=> irq);

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe && regAddr == 2'd0 && wBit0 && busy |=> ovrFlag);

  // R4
  err_no_dma_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !memValid);
endmodule

bind blkdma_top blkdma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .wBit0(regWdata[0]), .wBit1(regWdata[1]), .memValid(memValid),
  .memReady(memReady), .memAddr(memAddr), .memData(memData), .irq(irq),
  .busy(busy), .errFlag(errFlag), .ovrFlag(ovrFlag)
);

// File: tb/blkdma_top_tb_top.sv
`timescale 1ns/1ps
module blkdma_top_tb_top;
  localparam int SPT = 8, SURF = 2, TRK = 16, SPARE = 2;
  localparam int USABLE = SPT * SURF * (TRK - SPARE);
  localparam int NBEATS = 32;

  logic clk = 1'b0, rstN = 1'b0, regWe = 1'b0, memReady = 1'b1;
  logic [1:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata, memAddr, memData;
  logic memValid, irq;

  int checks = 0, fails = 0, beatCnt = 0, cyc = 0;
  bit bpMode = 1'b0;
  logic [31:0] capAddr [64];
  logic [31:0] capData [64];

  always #10 clk = ~clk;

  blkdma_top dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memValid(memValid),
    .memReady(memReady), .memAddr(memAddr), .memData(memData), .irq(irq)
  );

  always @(posedge clk) if (rstN && memValid && memReady) begin
    if (beatCnt < 64) begin
      capAddr[beatCnt] = memAddr;
      capData[beatCnt] = memData;
    end
    beatCnt = beatCnt + 1;
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    memReady = bpMode ? ((cyc % 3) != 0) : 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0; regWdata = '0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdata;
  endtask

  task automatic waitIrq(input string req);
    int n = 0;
    while (!irq && n < 500) begin @(negedge clk); n++; end
    check(irq === 1'b1, req, "irq after job", {31'b0, irq}, 32'h1);
  endtask

  function automatic logic [31:0] expWord(input int lba, input int idx);
    int q = lba / SPT;
    return {8'(q % SURF), 8'(q / SURF), 8'(lba % SPT), 8'(idx)};
  endfunction

  task automatic checkBeats(input int lba, input logic [31:0] dst, input string req);
    int bad = 0;
    check(beatCnt == NBEATS, "R5", "beat count", beatCnt, NBEATS);
    for (int i = 0; i < NBEATS && i < 64; i++) begin
      if (capAddr[i] !== dst + 32'(4 * i)) begin
        bad++;
        check(1'b0, "R5", "beat address", capAddr[i], dst + 32'(4 * i));
      end
      if (capData[i] !== expWord(lba, i)) begin
        bad++;
        check(1'b0, req, "beat data", capData[i], expWord(lba, i));
      end
    end
    check(bad == 0, req, "all beats", bad, 0);
  endtask

  task automatic runRead(input int lba, input logic [31:0] dst, input bit bp, input string req);
    logic [31:0] st;
    bpMode = bp;
    regWrite(2'd1, 32'(lba));
    regWrite(2'd2, dst);
    beatCnt = 0;
    regWrite(2'd0, 32'h1);
    waitIrq("R7");
    checkBeats(lba, dst, req);
    regRead(2'd3, st);
    check(st == 32'h2, "R7", "status after done", st, 32'h2);
    regWrite(2'd3, 32'h2);
    regRead(2'd3, st);
    check(st == 32'h0 && irq == 1'b0, "R7", "status after clear", st, 32'h0);
    bpMode = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] st;
    regRead(2'd3, st);
    check(st == 32'h0, "R1", "status at reset", st, 32'h0);
    check(!irq && !memValid, "R1", "irq/valid at reset", {30'b0, irq, memValid}, 32'h0);
  endtask

  task automatic testRegs();
    logic [31:0] v;
    regWrite(2'd1, 32'h0000_0055);
    regWrite(2'd2, 32'h0000_1000);
    regRead(2'd1, v); check(v == 32'h55, "R2", "lba readback", v, 32'h55);
    regRead(2'd2, v); check(v == 32'h1000, "R2", "dst readback", v, 32'h1000);
  endtask

  task automatic testRange(input int lba);
    logic [31:0] st;
    regWrite(2'd1, 32'(lba));
    beatCnt = 0;
    regWrite(2'd0, 32'h1);
    waitIrq("R4");
    repeat (40) @(negedge clk);
    check(beatCnt == 0, "R4", "no beats on range error", beatCnt, 0);
    regRead(2'd3, st);
    check(st == 32'h6, "R4", "error status", st, 32'h6);
    regWrite(2'd3, 32'h6);
    regRead(2'd3, st);
    check(st == 32'h0, "R7", "error cleared", st, 32'h0);
  endtask

  task automatic testOverrun();
    logic [31:0] st;
    regWrite(2'd1, 32'd5);
    regWrite(2'd2, 32'h0000_0400);
    beatCnt = 0;
    bpMode = 1'b1;
    regWrite(2'd0, 32'h1);
    regRead(2'd3, st);
    check(st[0] == 1'b1, "R10", "busy during job", st, 32'h1);
    regWrite(2'd1, 32'd100);
    regWrite(2'd2, 32'h0000_9000);
    regWrite(2'd0, 32'h1);
    regRead(2'd3, st);
    check(st[3] == 1'b1, "R8", "overrun bit", st, 32'h9);
    waitIrq("R8");
    repeat (40) @(negedge clk);
    checkBeats(5, 32'h0000_0400, "R8");
    regRead(2'd3, st);
    check(st == 32'hA, "R8", "status done+overrun", st, 32'hA);
    regWrite(2'd3, 32'hA);
    regRead(2'd3, st);
    check(st == 32'h0, "R7", "overrun cleared", st, 32'h0);
    bpMode = 1'b0;
  endtask

  task automatic testNoop();
    logic [31:0] st;
    beatCnt = 0;
    regWrite(2'd0, 32'h2);
    regRead(2'd3, st);
    check(st == 32'h0, "R9", "no busy after bit0=0", st, 32'h0);
    repeat (40) @(negedge clk);
    check(beatCnt == 0 && !irq, "R9", "no beats/irq", beatCnt, 0);
  endtask

  task automatic testIrqHold();
    logic [31:0] st;
    regWrite(2'd1, 32'd17);
    regWrite(2'd2, 32'h0000_3000);
    beatCnt = 0;
    regWrite(2'd0, 32'h1);
    waitIrq("R7");
    repeat (50) @(negedge clk);
    check(irq === 1'b1, "R7", "irq held", {31'b0, irq}, 32'h1);
    regWrite(2'd3, 32'h0);
    check(irq === 1'b1, "R7", "irq kept on write without bit1", {31'b0, irq}, 32'h1);
    regWrite(2'd3, 32'h2);
    regRead(2'd3, st);
    check(!irq && st == 32'h0, "R7", "irq cleared", st, 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegs();
    runRead(0, 32'h0000_1000, 1'b0, "R3");
    runRead(37, 32'h2000_0100, 1'b1, "R6");
    runRead(USABLE - 1, 32'h0000_8000, 1'b0, "R4");
    testRange(USABLE);
    testRange(300);
    testOverrun();
    testNoop();
    testIrqHold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule